// File: doc/BRIEF.md
# Serial Port Control and Interrupt Flag Block

This block is the software-facing front end of a serial port. It keeps an 8-bit control register and five sticky status flags: transmit buffer empty, receive buffer full, framing error, parity error and overrun. From these it raises three level interrupt requests. The CPU reaches both registers over a simple register bus with an address, a read strobe, a write strobe and write data. Read data is returned in the same cycle.

The serial datapath reports its events as single-cycle pulses. These are: transmit data moved into the shift register, receive data moved into the buffer, and the three receive error conditions. A status flag can be cleared only by a two-step handshake. Software must first read the status register and see the flag at 1. Then it must write 0 to that bit.

The clock-select and enable bits of the control register are not used inside the block. They are held and driven out to the baud and shift logic. A standby input forces the control register back to zero.

Top module: `serport_flag_ctrl`

## Requirements
- R1: The control register sits at address 0 and is read and written in full at any time. Its layout is bit7 transmit-interrupt enable, bit6 receive-interrupt enable, bit5 transmit enable, bit4 receive enable, bit3 multiprocessor-interrupt enable, bit2 transmit-end-interrupt enable, bits1:0 clock select. It resets to 0x00.
- R2: While `standby` is high, the control register is forced to 0x00 and writes to it are ignored.
- R3: The transmit-empty flag resets to 1. It is set by a `ev_tx_load` pulse.
- R4: The receive-full flag is set by `ev_rx_load`. The framing, parity and overrun flags are set by `ev_frame_err`, `ev_parity_err` and `ev_overrun`. All four reset to 0.
- R5: The status register sits at address 1. Its bits are: bit7 transmit-empty, bit6 receive-full, bit5 overrun, bit4 framing, bit3 parity. Bits 2:0 read 0.
- R6: A flag clears only on a status write of 0 to its bit that follows a status read which returned it as 1. A write of 0 with no such read leaves the flag set.
- R7: Writing 1 to a flag bit has no effect. Any status write uses up the read-as-one mark, so a later write of 0 needs a fresh read.
- R8: A set event in the same cycle as a qualifying clear wins, and the flag stays 1.
- R9: `irq_tx_empty` is high exactly while the transmit-empty flag and the transmit-interrupt enable are both 1.
- R10: `irq_rx_full` is receive-full AND receive-interrupt enable. `irq_rx_err` is (framing OR parity OR overrun) AND the same enable.
- R11: The enable and clock-select fields of the control register are driven out on `ctl_tx_en`, `ctl_rx_en`, `ctl_mp_ie`, `ctl_tend_ie` and `ctl_clk_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Standby; clears the control register |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, same cycle |
| ev_tx_load | input | 1 | Transmit data moved to the shift register |
| ev_rx_load | input | 1 | Receive data moved to the buffer |
| ev_frame_err | input | 1 | Framing error detected |
| ev_parity_err | input | 1 | Parity error detected |
| ev_overrun | input | 1 | Overrun detected |
| irq_tx_empty | output | 1 | Transmit-empty interrupt request |
| irq_rx_full | output | 1 | Receive-full interrupt request |
| irq_rx_err | output | 1 | Receive-error interrupt request |
| ctl_tx_en | output | 1 | Transmit enable |
| ctl_rx_en | output | 1 | Receive enable |
| ctl_mp_ie | output | 1 | Multiprocessor interrupt enable |
| ctl_tend_ie | output | 1 | Transmit-end interrupt enable |
| ctl_clk_sel | output | 2 | Clock source select |

## Verification
The bench writes 0 to flags that were never read. A design missing the read-as-one mark would lose pending events there. It also writes 1s to see that nothing gets set that way. It writes twice after one read, so a design that kept the mark past a status write would clear on the second write. A set pulse is driven in the same cycle as a legal clear, which catches a design that gives the clear priority. The bench also checks that the receive enable alone gates both receive requests, and that standby wipes the control register and blocks writes while it is held.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int DATA_W    = 8;
  localparam int NUM_FLAGS = 5;
  localparam int ADDR_W    = 1;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 1'b0;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 1'b1;

  // flag indices into the internal flag vector
  localparam int FL_TXE = 0;
  localparam int FL_RXF = 1;
  localparam int FL_FRM = 2;
  localparam int FL_PAR = 3;
  localparam int FL_ORN = 4;

  typedef struct packed {
    logic       tie;
    logic       rie;
    logic       te;
    logic       re;
    logic       mpie;
    logic       teie;
    logic [1:0] cks;
  } ctrl_t;

  // bit position of each flag in the status register
  function automatic int stat_pos(input int idx);
    case (idx)
      FL_TXE:  return 7;
      FL_RXF:  return 6;
      FL_ORN:  return 5;
      FL_FRM:  return 4;
      default: return 3;
    endcase
  endfunction

  function automatic logic flag_reset_val(input int idx);
    return (idx == FL_TXE);
  endfunction
endpackage

// File: rtl/serport_ctrl_reg.sv
module serport_ctrl_reg
  import serport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (standby) ctrl_q <= '0;
    else if (wr_en)   ctrl_q <= ctrl_t'(wdata);
  end

  assert_standby_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (ctrl_q == '0));

  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !standby) |=> (ctrl_q == $past(wdata)));
endmodule

// File: rtl/serport_flag.sv
module serport_flag #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic rd_stat,
  input  logic wr_stat,
  input  logic wr_bit,
  output logic flag_q
);
  logic armed_q;
  logic clr_ok;

  assign clr_ok = wr_stat && !wr_bit && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= RESET_VAL;
      armed_q <= 1'b0;
    end else begin
      if (set_ev)      flag_q <= 1'b1;
      else if (clr_ok) flag_q <= 1'b0;

      if (wr_stat)               armed_q <= 1'b0;
      else if (rd_stat && flag_q) armed_q <= 1'b1;
    end
  end

  assert_clear_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(armed_q && wr_stat && !wr_bit));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag_q);

  assert_no_sw_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_ev));
endmodule

// File: rtl/serport_irq.sv
module serport_irq
  import serport_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrl_t                ctrl,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic                 irq_tx_empty,
  output logic                 irq_rx_full,
  output logic                 irq_rx_err
);
  logic err_any;

  assign err_any      = flags[FL_FRM] | flags[FL_PAR] | flags[FL_ORN];
  assign irq_tx_empty = flags[FL_TXE] & ctrl.tie;
  assign irq_rx_full  = flags[FL_RXF] & ctrl.rie;
  assign irq_rx_err   = err_any & ctrl.rie;

  assert_rx_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx_full || irq_rx_err) |-> ctrl.rie);

  assert_tx_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_empty |-> ctrl.tie);
endmodule

// File: rtl/serport_flag_ctrl.sv
module serport_flag_ctrl
  import serport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ev_tx_load,
  input  logic              ev_rx_load,
  input  logic              ev_frame_err,
  input  logic              ev_parity_err,
  input  logic              ev_overrun,
  output logic              irq_tx_empty,
  output logic              irq_rx_full,
  output logic              irq_rx_err,
  output logic              ctl_tx_en,
  output logic              ctl_rx_en,
  output logic              ctl_mp_ie,
  output logic              ctl_tend_ie,
  output logic [1:0]        ctl_clk_sel
);
  ctrl_t                ctrl_q;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flag_vec;
  logic [DATA_W-1:0]    stat_word;
  logic                 ctrl_wr, stat_wr, stat_rd;

  assign ctrl_wr = reg_wr && (reg_addr == CTRL_ADDR);
  assign stat_wr = reg_wr && (reg_addr == STAT_ADDR);
  assign stat_rd = reg_rd && (reg_addr == STAT_ADDR);

  assign set_vec[FL_TXE] = ev_tx_load;
  assign set_vec[FL_RXF] = ev_rx_load;
  assign set_vec[FL_FRM] = ev_frame_err;
  assign set_vec[FL_PAR] = ev_parity_err;
  assign set_vec[FL_ORN] = ev_overrun;

  serport_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .standby (standby),
    .wr_en   (ctrl_wr),
    .wdata   (reg_wdata),
    .ctrl_q  (ctrl_q)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    serport_flag #(.RESET_VAL(flag_reset_val(i))) u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_ev  (set_vec[i]),
      .rd_stat (stat_rd),
      .wr_stat (stat_wr),
      .wr_bit  (reg_wdata[stat_pos(i)]),
      .flag_q  (flag_vec[i])
    );
  end

  always_comb begin
    stat_word = '0;
    for (int i = 0; i < NUM_FLAGS; i++) stat_word[stat_pos(i)] = flag_vec[i];
  end

  assign reg_rdata = (reg_addr == CTRL_ADDR) ? DATA_W'(ctrl_q) : stat_word;

  serport_irq u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl         (ctrl_q),
    .flags        (flag_vec),
    .irq_tx_empty (irq_tx_empty),
    .irq_rx_full  (irq_rx_full),
    .irq_rx_err   (irq_rx_err)
  );

  assign ctl_tx_en   = ctrl_q.te;
  assign ctl_rx_en   = ctrl_q.re;
  assign ctl_mp_ie   = ctrl_q.mpie;
  assign ctl_tend_ie = ctrl_q.teie;
  assign ctl_clk_sel = ctrl_q.cks;

  assert_unused_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == STAT_ADDR) |-> (reg_rdata[2:0] == 3'b000));
endmodule

// File: tb/tb_serport_flag_ctrl.sv
module tb_serport_flag_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby = 1'b0;
  logic reg_addr = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic ev_tx_load = 0, ev_rx_load = 0, ev_frame_err = 0, ev_parity_err = 0, ev_overrun = 0;
  logic irq_tx_empty, irq_rx_full, irq_rx_err;
  logic ctl_tx_en, ctl_rx_en, ctl_mp_ie, ctl_tend_ie;
  logic [1:0] ctl_clk_sel;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serport_flag_ctrl dut (.*);

  // op[22:21] 0 write, 1 read-check, 2 event pulse, 3 irq check {err,rx,tx}
  // addr[20], data[19:12], expected[11:4], requirement number[3:0]
  localparam int NV = 25;
  localparam logic [22:0] VEC [0:NV-1] = '{
    {2'd1, 1'b0, 8'h00, 8'h00, 4'd1},
    {2'd1, 1'b1, 8'h00, 8'h80, 4'd3},
    {2'd0, 1'b0, 8'hB6, 8'h00, 4'd1},
    {2'd1, 1'b0, 8'h00, 8'hB6, 4'd1},
    {2'd3, 1'b0, 8'h00, 8'h01, 4'd9},
    {2'd2, 1'b0, 8'h06, 8'h00, 4'd4},
    {2'd1, 1'b1, 8'h00, 8'hD0, 4'd5},
    {2'd3, 1'b0, 8'h00, 8'h01, 4'd10},
    {2'd0, 1'b0, 8'h40, 8'h00, 4'd1},
    {2'd3, 1'b0, 8'h00, 8'h06, 4'd10},
    {2'd0, 1'b1, 8'h00, 8'h00, 4'd6},
    {2'd1, 1'b1, 8'h00, 8'h00, 4'd6},
    {2'd3, 1'b0, 8'h00, 8'h00, 4'd10},
    {2'd2, 1'b0, 8'h18, 8'h00, 4'd4},
    {2'd0, 1'b1, 8'h00, 8'h00, 4'd6},
    {2'd1, 1'b1, 8'h00, 8'h28, 4'd6},
    {2'd0, 1'b1, 8'hFF, 8'h00, 4'd7},
    {2'd1, 1'b1, 8'h00, 8'h28, 4'd7},
    {2'd3, 1'b0, 8'h00, 8'h04, 4'd10},
    {2'd0, 1'b1, 8'h00, 8'h00, 4'd6},
    {2'd1, 1'b1, 8'h00, 8'h00, 4'd6},
    {2'd2, 1'b0, 8'h01, 8'h00, 4'd3},
    {2'd0, 1'b0, 8'h80, 8'h00, 4'd1},
    {2'd3, 1'b0, 8'h00, 8'h01, 4'd9},
    {2'd1, 1'b0, 8'h00, 8'h80, 4'd1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 check(req, reg_rdata, exp);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk);
    {ev_overrun, ev_parity_err, ev_frame_err, ev_rx_load, ev_tx_load} = m;
    @(negedge clk);
    {ev_overrun, ev_parity_err, ev_frame_err, ev_rx_load, ev_tx_load} = '0;
  endtask

  task automatic irq_check(input logic [7:0] exp, input string req);
    @(negedge clk);
    #1 check(req, {5'b0, irq_rx_err, irq_rx_full, irq_tx_empty}, exp);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state: R1 R3 R4 R9 R11
    #1 check("R9 reset irq", {5'b0, irq_rx_err, irq_rx_full, irq_tx_empty}, 8'h00);
    check("R11 reset exports", {3'b0, ctl_tx_en, ctl_rx_en, ctl_mp_ie, ctl_tend_ie, 1'b0}, 8'h00);
    rst_n = 1'b1;
    do_read(1'b1, 8'h80, "R4 reset status");

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic a;
      logic [7:0] d, e;
      string rq;
      {op, a, d, e} = VEC[i][22:4];
      rq = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      case (op)
        2'd0: do_write(a, d);
        2'd1: do_read(a, e, rq);
        2'd2: pulse(d[4:0]);
        default: irq_check(e, rq);
      endcase
    end

    // R2: standby clears and blocks writes
    do_write(1'b0, 8'hFF);
    @(negedge clk);
    standby = 1'b1;
    reg_addr = 1'b0; reg_wdata = 8'h5A; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    do_read(1'b0, 8'h00, "R2 standby");
    standby = 1'b0;
    do_read(1'b0, 8'h00, "R2 write during standby ignored");

    // R11: exported fields
    do_write(1'b0, 8'h3D);
    #1 check("R11 exports", {2'b0, ctl_tx_en, ctl_rx_en, ctl_mp_ie, ctl_tend_ie, ctl_clk_sel}, 8'h3D);

    // R8: set in the same cycle as a legal clear
    do_read(1'b1, 8'h80, "R8 arm txe");
    @(negedge clk);
    reg_addr = 1'b1; reg_wdata = 8'h00; reg_wr = 1'b1; ev_tx_load = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ev_tx_load = 1'b0;
    do_read(1'b1, 8'h80, "R8 set wins");

    // R7: second write of 0 after a single read does not clear
    do_write(1'b1, 8'h80);
    do_write(1'b1, 8'h00);
    do_read(1'b1, 8'h80, "R7 mark consumed");
    do_write(1'b1, 8'h00);
    do_read(1'b1, 8'h00, "R6 clear after read");

    // R3: tx load sets again
    pulse(5'b00001);
    do_read(1'b1, 8'h80, "R3 tx load sets");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule